// File: doc/BRIEF.md
# EEPROM Write-Completion Poller

After a host has issued a byte or page write to a parallel EEPROM, the part runs a self-timed programming cycle. During that cycle it is not ready for new accesses. This block lets the host find out when that cycle has ended. The host pulses `start_i` and supplies the address and value of the last byte it wrote, a poll budget and a detection method. The block then works on its own until it ends the poll with exactly one one-cycle outcome pulse.

There are three detection methods:

- **Data-bit method.** The block reads back the last written address. While programming is in progress, bit 7 of each read is the inverse of the bit that was written.
- **Toggle method.** The block reads repeatedly. Bit 6 flips between consecutive reads while programming is in progress.
- **Ready line method.** The block watches an external active-low busy line. It issues no reads in this mode.

For the two bus methods, one extra confirming read follows the detection. The value of that read separates a clean finish from a failed write. Reads go out through a request/acknowledge read port, with a parameterised minimum spacing between reads.

Top module: `eeprom_wpoll`

## Requirements
- R1: After reset the block is idle. `busy_o`, `rd_req_o`, `done_o`, `timeout_o` and `wr_err_o` are all low, and no read is requested until a start is accepted.
- R2: With `mode_i` = 2'b00 (data-bit method), every read targets the latched address. A read whose bit 7 differs from bit 7 of the written byte counts as busy, and polling continues. Bits 0 to 6 of such reads have no effect on the outcome or on the number of reads.
- R3: In the data-bit method, the first read whose bit 7 equals the written bit 7 ends detection, whatever its bits 0 to 6 hold. Exactly one further read of the same address follows.
- R4: With `mode_i` = 2'b01 (toggle method), the first read only records bit 6. Each later read whose bit 6 differs from that of the previous read counts as busy. The first read whose bit 6 equals the previous one ends detection, and exactly one further read follows.
- R5: The confirming read in R3 and R4 gives the outcome. If it equals the written byte on all 8 bits, `done_o` pulses. Otherwise `wr_err_o` pulses.
- R6: When the count of busy observations reaches `max_polls_i`, `timeout_o` pulses and no further read is issued. A value of 0 behaves as 1.
- R7: With `mode_i[1]` = 1 (ready line method), no read is issued. `rb_n_i` passes through a two-flop synchroniser and is ignored for `RB_HOLDOFF` cycles after the start. After that, each clock a high sample gives `done_o`, and each low sample counts as one busy observation for R6.
- R8: `start_i` has no effect while `busy_o` is high. The address, the expected byte and the mode in use stay unchanged.
- R9: A read request is held until acknowledged. A new request is raised only after at least `READ_GAP` cycles without a request.
- R10: Each poll ends with exactly one of `done_o`, `timeout_o`, `wr_err_o`, high for a single cycle. `busy_o` is low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a poll (taken only when idle) |
| mode_i | input | 2 | 00 data-bit, 01 toggle, 1x ready line |
| addr_i | input | ADDR_W | Address of the last byte written |
| wdata_i | input | DATA_W | Value of the last byte written |
| max_polls_i | input | CNT_W | Busy observations allowed before timeout |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ack_i | input | 1 | Read acknowledge; data valid in the same cycle |
| rd_data_i | input | DATA_W | Read data |
| rb_n_i | input | 1 | Ready/busy line, low means busy (asynchronous) |
| busy_o | output | 1 | A poll is in progress |
| done_o | output | 1 | One-cycle pulse: programming finished and data confirmed |
| timeout_o | output | 1 | One-cycle pulse: poll budget exhausted |
| wr_err_o | output | 1 | One-cycle pulse: confirming read mismatched |

## Verification
Some wrong internal states show as a wrong number of reads before the outcome pulse, measured against a model of the memory that returns a scripted busy sequence. Examples are a miscounted busy tally, a lost record of the previous bit 6, or a skipped confirming read. They appear in the very poll where they occur. A corrupted latched address shows at the read port on the next read. A wrong final comparison shows as the wrong outcome pulse at the end of that poll. In the ready line method, a missing hold-off or synchroniser shows as an outcome that arrives earlier than the hold-off allows, or as a timeout when a short low glitch falls inside the hold-off.

// File: rtl/eeprom_wpoll_pkg.sv
package eeprom_wpoll_pkg;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_POLL   = 2'd1,
    S_VERIFY = 2'd2,
    S_RB     = 2'd3
  } wp_state_e;

  typedef enum logic [1:0] {
    E_IDLE = 2'd0,
    E_GAP  = 2'd1,
    E_REQ  = 2'd2
  } eng_state_e;

  // Data-bit method: a read is still busy when the status bit is inverted.
  function automatic logic dp_busy(input logic rd_bit, input logic wr_bit);
    return rd_bit != wr_bit;
  endfunction

  // Toggle method: busy while the toggle bit moved since the previous read.
  function automatic logic tg_busy(input logic prev_bit, input logic rd_bit);
    return prev_bit != rd_bit;
  endfunction

  // The current busy observation is the last one the budget allows.
  function automatic logic limit_hit(input logic [31:0] cnt, input logic [31:0] lim);
    return (cnt + 32'd1) >= lim;
  endfunction

endpackage

// File: rtl/eeprom_wpoll_rdeng.sv
module eeprom_wpoll_rdeng
  import eeprom_wpoll_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int READ_GAP = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick_i,
  output logic              rd_req_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              rsp_vld_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  localparam int GW = (READ_GAP < 1) ? 1 : $clog2(READ_GAP + 1);

  eng_state_e      st_q;
  logic [GW-1:0]   gap_q;
  logic [GW:0]     idle_run_q;

  assign rd_req_o = (st_q == E_REQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= E_IDLE;
      gap_q      <= '0;
      rsp_vld_o  <= 1'b0;
      rsp_data_o <= '0;
    end else begin
      rsp_vld_o <= 1'b0;
      unique case (st_q)
        E_IDLE: if (kick_i) begin
          gap_q <= GW'(READ_GAP);
          st_q  <= E_GAP;
        end
        E_GAP: begin
          if (gap_q == '0) st_q <= E_REQ;
          else             gap_q <= gap_q - 1'b1;
        end
        E_REQ: if (rd_ack_i) begin
          rsp_vld_o  <= 1'b1;
          rsp_data_o <= rd_data_i;
          st_q       <= E_IDLE;
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end

  // Independent tally of request-free cycles, used only by the checks.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         idle_run_q <= '0;
    else if (rd_ack_i)                  idle_run_q <= '0;
    else if (!rd_req_o && (idle_run_q < (GW+1)'(READ_GAP)))
      idle_run_q <= idle_run_q + 1'b1;
  end

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ack_i) |=> rd_req_o);
  p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req_o) |-> (idle_run_q >= (GW+1)'(READ_GAP)));
  p_kick_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |-> (st_q == E_IDLE));

endmodule

// File: rtl/eeprom_wpoll_rbmon.sv
module eeprom_wpoll_rbmon #(
  parameter int RB_HOLDOFF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic rb_n_i,
  output logic sample_ok_o,
  output logic ready_o
);
  localparam int HW = (RB_HOLDOFF < 1) ? 1 : $clog2(RB_HOLDOFF + 1);

  logic          s1_q, s2_q;
  logic [HW-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= rb_n_i;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hold_q <= '0;
    else if (arm_i)          hold_q <= HW'(RB_HOLDOFF);
    else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
  end

  assign ready_o     = s2_q;
  assign sample_ok_o = (hold_q == '0) && !arm_i;

  generate
    if (RB_HOLDOFF > 0) begin : g_hold_chk
      p_holdoff_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> !sample_ok_o);
    end
  endgenerate
  p_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(s1_q));

endmodule

// File: rtl/eeprom_wpoll.sv
module eeprom_wpoll
  import eeprom_wpoll_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 16,
  parameter int READ_GAP   = 3,
  parameter int RB_HOLDOFF = 4,
  parameter int DP_BIT     = 7,
  parameter int TG_BIT     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  max_polls_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rb_n_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              wr_err_o
);
  wp_state_e         st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] exp_q;
  logic              tog_q;
  logic [CNT_W-1:0]  max_q, cnt_q;
  logic              prev_q, have_prev_q, kick_q;

  logic              rsp_vld;
  logic [DATA_W-1:0] rsp_data;
  logic              rb_ok, rb_ready;

  // Named events for the checks and for readability.
  logic start_ok, first_tog, poll_busy, ev_limit, ev_match, outcome;

  assign start_ok  = start_i && (st_q == S_IDLE);
  assign first_tog = tog_q && !have_prev_q;
  assign poll_busy = tog_q ? tg_busy(prev_q, rsp_data[TG_BIT])
                           : dp_busy(rsp_data[DP_BIT], exp_q[DP_BIT]);
  assign ev_limit  = limit_hit(32'(cnt_q), 32'(max_q));
  assign ev_match  = (rsp_data == exp_q);
  assign outcome   = done_o || timeout_o || wr_err_o;

  assign busy_o    = (st_q != S_IDLE);
  assign rd_addr_o = addr_q;

  eeprom_wpoll_rdeng #(.DATA_W(DATA_W), .READ_GAP(READ_GAP)) u_rdeng (
    .clk        (clk),
    .rst_n      (rst_n),
    .kick_i     (kick_q),
    .rd_req_o   (rd_req_o),
    .rd_ack_i   (rd_ack_i),
    .rd_data_i  (rd_data_i),
    .rsp_vld_o  (rsp_vld),
    .rsp_data_o (rsp_data)
  );

  eeprom_wpoll_rbmon #(.RB_HOLDOFF(RB_HOLDOFF)) u_rbmon (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm_i       (start_ok && mode_i[1]),
    .rb_n_i      (rb_n_i),
    .sample_ok_o (rb_ok),
    .ready_o     (rb_ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      addr_q      <= '0;
      exp_q       <= '0;
      tog_q       <= 1'b0;
      max_q       <= '0;
      cnt_q       <= '0;
      prev_q      <= 1'b0;
      have_prev_q <= 1'b0;
      kick_q      <= 1'b0;
      done_o      <= 1'b0;
      timeout_o   <= 1'b0;
      wr_err_o    <= 1'b0;
    end else begin
      kick_q    <= 1'b0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      wr_err_o  <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          addr_q      <= addr_i;
          exp_q       <= wdata_i;
          tog_q       <= (mode_i == 2'b01);
          max_q       <= max_polls_i;
          cnt_q       <= '0;
          have_prev_q <= 1'b0;
          if (mode_i[1]) st_q <= S_RB;
          else begin
            st_q   <= S_POLL;
            kick_q <= 1'b1;
          end
        end
        S_POLL: if (rsp_vld) begin
          if (first_tog) begin
            prev_q      <= rsp_data[TG_BIT];
            have_prev_q <= 1'b1;
            kick_q      <= 1'b1;
          end else if (poll_busy) begin
            if (ev_limit) begin
              timeout_o <= 1'b1;
              st_q      <= S_IDLE;
            end else begin
              cnt_q  <= cnt_q + 1'b1;
              prev_q <= rsp_data[TG_BIT];
              kick_q <= 1'b1;
            end
          end else begin
            st_q   <= S_VERIFY;
            kick_q <= 1'b1;
          end
        end
        S_VERIFY: if (rsp_vld) begin
          st_q <= S_IDLE;
          if (ev_match) done_o   <= 1'b1;
          else          wr_err_o <= 1'b1;
        end
        S_RB: if (rb_ok) begin
          if (rb_ready) begin
            done_o <= 1'b1;
            st_q   <= S_IDLE;
          end else if (ev_limit) begin
            timeout_o <= 1'b1;
            st_q      <= S_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, timeout_o, wr_err_o}));
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    outcome |=> !outcome);
  p_idle_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    outcome |-> !busy_o);
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(rd_addr_o) && $stable(exp_q) && $stable(tog_q)));
  p_no_bus_rb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RB) |-> !rd_req_o);
  p_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> ($past(busy_o) && (32'(cnt_q) + 32'd1 >= 32'(max_q))));
  p_verify_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !$past(st_q == S_RB)) |-> $past(st_q == S_VERIFY));
  p_werr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err_o |-> $past(st_q == S_VERIFY));

endmodule

// File: tb/eeprom_wpoll_bench.sv
`timescale 1ns/1ps
module eeprom_wpoll_bench;
  localparam int AW = 13, DW = 8, CW = 16, GAP = 3, HOLD = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [CW-1:0] max_polls_i = '0;
  logic rd_req_o, rd_ack_i = 1'b0;
  logic [AW-1:0] rd_addr_o;
  logic [DW-1:0] rd_data_i = '0;
  logic rb_n_i = 1'b1;
  logic busy_o, done_o, timeout_o, wr_err_o;

  int checks = 0, errors = 0;
  // scenario state shared with the memory model
  int sc_mode = 0, sc_n = 0, rd_cnt = 0, addr_bad = 0;
  logic [DW-1:0] sc_exp = '0;
  logic [AW-1:0] sc_addr = '0;
  bit sc_err = 0;

  always #4 clk = ~clk;

  eeprom_wpoll #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .READ_GAP(GAP),
                 .RB_HOLDOFF(HOLD)) u_eeprom_wpoll (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .max_polls_i(max_polls_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
    .rd_data_i(rd_data_i), .rb_n_i(rb_n_i), .busy_o(busy_o),
    .done_o(done_o), .timeout_o(timeout_o), .wr_err_o(wr_err_o));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Scripted memory: busy reads for sc_n, then settled data.
  function automatic logic [DW-1:0] mem_byte(input int k);
    logic [DW-1:0] r = DW'($urandom);
    if (sc_mode == 0) begin
      if (k < sc_n)       r[7] = ~sc_exp[7];
      else if (k == sc_n) r[7] = sc_exp[7];
      else                r = sc_err ? (sc_exp ^ 8'h01) : sc_exp;
    end else begin
      if (k <= sc_n)          r[6] = sc_exp[6] ^ 1'((sc_n - k) & 1);
      else if (k == sc_n + 1) r = sc_exp;
      else                    r = sc_err ? (sc_exp ^ 8'h01) : sc_exp;
    end
    return r;
  endfunction

  // Expected outcome: 0 done, 1 timeout, 2 write error; and read count.
  function automatic int exp_outcome(input int n, input int mx, input bit er);
    int m = (mx == 0) ? 1 : mx;
    if (n >= m) return 1;
    return er ? 2 : 0;
  endfunction
  function automatic int exp_reads(input int md, input int n, input int mx);
    int m = (mx == 0) ? 1 : mx;
    if (md == 0) return (n >= m) ? m : n + 2;
    return (n >= m) ? m + 1 : n + 3;
  endfunction

  initial begin : memory_model
    forever begin
      @(negedge clk);
      if (rd_req_o && !rd_ack_i) begin
        if (rd_addr_o !== sc_addr) addr_bad++;
        rd_data_i = mem_byte(rd_cnt);
        rd_ack_i  = 1'b1;
        rd_cnt++;
      end else begin
        rd_ack_i = 1'b0;
      end
    end
  end

  // Runs one poll; rb_low = cycles the ready line stays low (ready modes).
  task automatic run_poll(input int md, input int n, input int mx, input bit er,
                          input int rb_low, output int outc, output int lat);
    int cyc = 0;
    bit injected = 0;
    sc_mode = md; sc_n = n; sc_err = er;
    sc_exp = DW'($urandom); sc_addr = AW'($urandom);
    rd_cnt = 0; addr_bad = 0; outc = -1;
    @(negedge clk);
    mode_i = (md == 2) ? 2'b10 : 2'(md);
    addr_i = sc_addr; wdata_i = sc_exp; max_polls_i = CW'(mx);
    rb_n_i = (md == 2 && rb_low > 0) ? 1'b0 : 1'b1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1;
    while (outc < 0) begin
      if (md == 2 && cyc >= rb_low) rb_n_i = 1'b1;
      if (done_o) outc = 0;
      else if (timeout_o) outc = 1;
      else if (wr_err_o) outc = 2;
      if (outc < 0) begin
        if (start_i) start_i = 1'b0;
        else if (!injected && cyc == 3 && busy_o) begin
          injected = 1;                 // R8: start while busy, other inputs
          addr_i = ~sc_addr; wdata_i = ~sc_exp; mode_i = (md == 2) ? 2'b00 : 2'b10;
          start_i = 1'b1;
        end
        @(negedge clk);
        cyc++;
      end
    end
    lat = cyc;
    start_i = 1'b0;
    chk(busy_o == 1'b0, "R10", "busy low with outcome", busy_o, 0);
    @(negedge clk);
    chk({done_o, timeout_o, wr_err_o} == 3'b000, "R10", "single-cycle pulse",
        {done_o, timeout_o, wr_err_o}, 0);
    repeat (2 * GAP + 6) @(negedge clk);
    chk(busy_o == 1'b0 && rd_req_o == 1'b0, "R8", "no poll from ignored start",
        {busy_o, rd_req_o}, 0);
    chk(addr_bad == 0, "R2", "reads at latched address", addr_bad, 0);
    rb_n_i = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int o, l, md, n, mx;
    bit er;
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    chk({busy_o, rd_req_o, done_o, timeout_o, wr_err_o} == 5'b0, "R1",
        "reset outputs", {busy_o, rd_req_o, done_o, timeout_o, wr_err_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy_o, rd_req_o} == 2'b0, "R1", "idle after reset", {busy_o, rd_req_o}, 0);

    // Directed: data-bit method, immediate completion (R3), busy then done (R2).
    run_poll(0, 0, 4, 0, 0, o, l);
    chk(o == 0, "R3", "data-bit immediate done", o, 0);
    chk(rd_cnt == 2, "R3", "detect plus confirm read", rd_cnt, 2);
    run_poll(0, 3, 8, 0, 0, o, l);
    chk(o == 0 && rd_cnt == 5, "R2", "data-bit busy reads", rd_cnt, 5);
    // Toggle method: first read only recorded (R4).
    run_poll(1, 0, 1, 0, 0, o, l);
    chk(o == 0 && rd_cnt == 3, "R4", "toggle settled at once", rd_cnt, 3);
    run_poll(1, 4, 9, 1, 0, o, l);
    chk(o == 2, "R5", "toggle confirm mismatch", o, 2);
    run_poll(0, 2, 5, 1, 0, o, l);
    chk(o == 2, "R5", "data-bit confirm mismatch", o, 2);
    // Timeout boundaries (R6), including budget 0.
    run_poll(0, 3, 3, 0, 0, o, l);
    chk(o == 1 && rd_cnt == 3, "R6", "data-bit timeout at budget", rd_cnt, 3);
    run_poll(1, 5, 2, 0, 0, o, l);
    chk(o == 1 && rd_cnt == 3, "R6", "toggle timeout reads", rd_cnt, 3);
    run_poll(0, 2, 0, 0, 0, o, l);
    chk(o == 1 && rd_cnt == 1, "R6", "budget zero acts as one", rd_cnt, 1);
    // Ready line method (R7).
    run_poll(2, 0, 5, 0, 0, o, l);
    chk(o == 0 && rd_cnt == 0, "R7", "ready line high gives done", o, 0);
    chk(l >= HOLD + 1, "R7", "hold-off respected", l, HOLD + 1);
    run_poll(2, 2, 1, 0, 2, o, l);
    chk(o == 0, "R7", "low inside hold-off ignored", o, 0);
    run_poll(2, 0, 40, 0, 12, o, l);
    chk(o == 0 && rd_cnt == 0, "R7", "low then high gives done", o, 0);
    run_poll(2, 0, 10, 0, 100000, o, l);
    chk(o == 1 && rd_cnt == 0, "R6", "ready line stuck low times out", o, 1);

    // Constrained random over the bus methods (R2..R6, R9).
    for (int i = 0; i < 30; i++) begin
      md = int'($urandom_range(1, 0));
      n  = int'($urandom_range(6, 0));
      mx = int'($urandom_range(8, 1));
      er = 1'($urandom_range(1, 0));
      run_poll(md, n, mx, er, 0, o, l);
      chk(o == exp_outcome(n, mx, er), (md == 0) ? "R3" : "R4",
          "random outcome", o, exp_outcome(n, mx, er));
      chk(rd_cnt == exp_reads(md, n, mx), "R9", "random read count", rd_cnt,
          exp_reads(md, n, mx));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule